// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Detection

This block turns an asynchronous serial line into characters. A free-running enable that pulses sixteen times per bit paces it. The receiver confirms a start bit at its centre. It then samples 5 to 8 data bits, least significant first, and an optional even or odd parity bit. Finally it takes one sample of the stop level. Each finished character goes into a three-entry queue together with its own error flags.

A character that arrives all low with a low stop sample is a line break. A break takes one queue slot. After a break, the receiver accepts no new start until the line has stayed high for half a bit.

A status byte gives the head-of-queue flags, a sticky overrun bit, a full indication and a data-ready bit. The byte also carries two transmitter status inputs unchanged. A consumer reads `rx_data` and pulses `pop` to advance the queue.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, with both transmitter inputs low, `status` reads 0x00 and the queue is empty.
- R2: Data bits are taken least significant first. `char_len` selects 5, 6, 7 or 8 bits (codes 0 to 3). The head character appears right-justified on `rx_data`, with unused upper bits at zero.
- R3: A low level seen at a tick starts a candidate frame. If the line is high again 8 ticks later, the candidate is dropped and nothing is queued.
- R4: With `par_on` set, the bit after the data is the parity bit. Even parity expects the XOR of the data bits, and `par_odd` selects odd parity, which expects the inverse. A mismatch sets status bit 5 for that character.
- R5: The stop level is sampled once, 16 ticks after the last data or parity sample. A low sample sets status bit 6 for that character.
- R6: A character whose data bits, parity bit (if enabled) and stop sample are all low is a break. It occupies exactly one queue entry, with status bits 7 and 6 set and bit 5 clear.
- R7: After a break, no character is accepted until the line has been high for 8 consecutive ticks. A shorter high pulse restarts that count.
- R8: When a break begins partway through a character, that character is queued with a framing error. The break itself is reported with the following character time.
- R9: The queue holds 3 entries in arrival order. Status bit 1 is set while all 3 are occupied, and bit 0 is set while at least one is.
- R10: A character that completes while the queue is full is discarded and sets status bit 4. Bit 4 stays set until `clr_err` is pulsed.
- R11: Status bits 7, 6 and 5 and `rx_data` read zero while the queue is empty.
- R12: Status bits 3 and 2 follow `tx_empty_in` and `tx_ready_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_on | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| pop | input | 1 | Remove the head entry |
| clr_err | input | 1 | Clear the sticky overrun bit |
| tx_empty_in | input | 1 | Transmitter-empty flag passed to status bit 3 |
| tx_ready_in | input | 1 | Transmitter-ready flag passed to status bit 2 |
| rx_data | output | 8 | Head character, right-justified |
| status | output | 8 | {break, framing, parity, overrun, tx empty, tx ready, full, ready} |

## Verification
The hardest cases to reach are the break that starts mid-character and the break inhibit window. Only the exact shape of the line waveform over many bit times leads into them. For the first case, the stimulus sends a start bit and three high data bits, then holds the line low for over twenty bit times. The queue must then hold a framing-error character followed by a single break. For the inhibit window, a five-tick high glitch is placed between two long low stretches. The check is that neither the glitch nor the second low stretch adds an entry, and that a normal character afterwards is received.

// File: rtl/srx_pkg.sv
// Shared types for the serial receiver: queue entry layout and frame states.
package srx_pkg;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRKWAIT
    } rx_state_e;

endpackage

// File: rtl/srx_bit_engine.sv
// Frame engine: validates the start bit, shifts in data and parity, samples the stop
// level once, and classifies the frame. Raises push for one cycle with the entry.
// Assumes os_tick pulses OVS times per bit and that configuration is stable during a frame.
module srx_bit_engine
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            os_tick,
    input  logic            rxd,
    input  logic [1:0]      char_len,
    input  logic            par_on,
    input  logic            par_odd,
    output logic            push,
    output rx_entry_t       push_entry
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] FULL_T = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF_T = CW'(OVS / 2 - 1);

    rx_state_e      st;
    logic [CW-1:0]  cnt;
    logic [2:0]     idx;
    logic [7:0]     shreg;
    logic           parbit;
    logic [2:0]     last_idx;
    logic           brk_c;
    logic           pe_c;

    // Index of the final data bit for the selected length.
    assign last_idx = {1'b0, char_len} + 3'd4;

    // Classify the frame at the stop sample.
    always_comb begin
        brk_c = (shreg == 8'h00) && !(par_on && parbit) && !rxd;
        pe_c  = par_on && (parbit != (^shreg ^ par_odd)) && !brk_c;
    end

    // Frame sequencing, paced by the oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            cnt        <= '0;
            idx        <= '0;
            shreg      <= '0;
            parbit     <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push <= 1'b0;
            if (os_tick) begin
                case (st)
                    S_IDLE: begin
                        if (!rxd) begin
                            st  <= S_START;
                            cnt <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == HALF_T) begin
                            cnt <= '0;
                            if (rxd) begin
                                st <= S_IDLE;
                            end else begin
                                st     <= S_DATA;
                                idx    <= '0;
                                shreg  <= '0;
                                parbit <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == FULL_T) begin
                            cnt        <= '0;
                            shreg[idx] <= rxd;
                            if (idx == last_idx) st <= par_on ? S_PAR : S_STOP;
                            else                 idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == FULL_T) begin
                            cnt    <= '0;
                            parbit <= rxd;
                            st     <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == FULL_T) begin
                            cnt        <= '0;
                            push       <= 1'b1;
                            push_entry <= '{brk: brk_c, fe: !rxd, pe: pe_c, data: shreg};
                            st         <= brk_c ? S_BRKWAIT : S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_BRKWAIT: begin
                        if (!rxd)               cnt <= '0;
                        else if (cnt == HALF_T) begin
                            cnt <= '0;
                            st  <= S_IDLE;
                        end else                cnt <= cnt + 1'b1;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/srx_fifo.sv
// Small circular queue of receive entries. A push while full is refused and flagged
// on dropped; a pop while empty does nothing. Assumes DEPTH >= 2.
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t wdata,
    input  logic      pop,
    output rx_entry_t rdata,
    output logic      empty,
    output logic      full,
    output logic      dropped
);
    localparam int PW = $clog2(DEPTH);
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);
    localparam logic [NW-1:0] DEPTH_N = NW'(DEPTH);

    rx_entry_t      mem [DEPTH];
    logic [PW-1:0]  wr_p;
    logic [PW-1:0]  rd_p;
    logic [NW-1:0]  used;
    logic           do_push;
    logic           do_pop;

    assign empty   = (used == '0);
    assign full    = (used == DEPTH_N);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dropped = push && full;
    assign rdata   = mem[rd_p];

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_p] <= wdata;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p <= '0;
            rd_p <= '0;
            used <= '0;
        end else begin
            if (do_push) wr_p <= (wr_p == LAST_P) ? '0 : wr_p + 1'b1;
            if (do_pop)  rd_p <= (rd_p == LAST_P) ? '0 : rd_p + 1'b1;
            case ({do_push, do_pop})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end

endmodule

// File: rtl/serial_rx_status.sv
// Top of the serial receiver: frame engine, entry queue, sticky overrun and status byte.
// Head-of-queue flags are gated by data-ready; transmitter flags pass through.
module serial_rx_status
    import srx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic       par_on,
    input  logic       par_odd,
    input  logic       pop,
    input  logic       clr_err,
    input  logic       tx_empty_in,
    input  logic       tx_ready_in,
    output logic [7:0] rx_data,
    output logic [7:0] status
);
    logic      eng_push;
    rx_entry_t eng_entry;
    rx_entry_t head;
    logic      q_empty;
    logic      q_full;
    logic      q_drop;
    logic      ovr_q;
    logic      rdy;

    srx_bit_engine #(.OVS(OVS)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .rxd        (rxd),
        .char_len   (char_len),
        .par_on     (par_on),
        .par_odd    (par_odd),
        .push       (eng_push),
        .push_entry (eng_entry)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (eng_push),
        .wdata   (eng_entry),
        .pop     (pop),
        .rdata   (head),
        .empty   (q_empty),
        .full    (q_full),
        .dropped (q_drop)
    );

    // Sticky overrun: the clear command has priority over a new overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (clr_err) ovr_q <= 1'b0;
        else if (q_drop)  ovr_q <= 1'b1;
    end

    assign rdy     = !q_empty;
    assign rx_data = rdy ? head.data : 8'h00;
    assign status  = {rdy & head.brk, rdy & head.fe, rdy & head.pe, ovr_q,
                      tx_empty_in, tx_ready_in, q_full, rdy};

endmodule

// File: rtl/serial_rx_status_chk.sv
// Checker for serial_rx_status: relations between status bits and command inputs over time.
module serial_rx_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_err,
    input logic       tx_empty_in,
    input logic       tx_ready_in,
    input logic [7:0] rx_data,
    input logic [7:0] status
);
    // R11: no head flags and no data without a ready character
    p_flags_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] |-> (status[7:5] == 3'b000 && rx_data == 8'h00));

    // R6: a break entry always carries a framing error and no parity error
    p_break_framing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] |-> (status[6] && !status[5]));

    // R9: full implies ready
    p_full_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> status[0]);

    // R10: overrun persists until the clear command
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !clr_err) |=> status[4]);

    // R10: the clear command removes overrun
    p_ovr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> !status[4]);

    // R12: transmitter flags pass through
    p_tx_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] == tx_empty_in) && (status[2] == tx_ready_in));

endmodule

bind serial_rx_status serial_rx_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_err     (clr_err),
    .tx_empty_in (tx_empty_in),
    .tx_ready_in (tx_ready_in),
    .rx_data     (rx_data),
    .status      (status)
);

// File: tb/serial_rx_status_test.sv
module serial_rx_status_test;
    localparam int BIT = 64;   // 16 ticks of 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       rxd = 1'b1;
    logic [1:0] char_len = 2'd3;
    logic       par_on = 1'b0;
    logic       par_odd = 1'b0;
    logic       pop = 1'b0;
    logic       clr_err = 1'b0;
    logic       tx_empty_in = 1'b0;
    logic       tx_ready_in = 1'b0;
    logic [7:0] rx_data;
    logic [7:0] status;
    logic [1:0] tdiv;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tdiv <= '0;
        else        tdiv <= tdiv + 1'b1;
    end
    assign os_tick = (tdiv == 2'd3);

    serial_rx_status uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .char_len(char_len), .par_on(par_on), .par_odd(par_odd),
        .pop(pop), .clr_err(clr_err), .tx_empty_in(tx_empty_in),
        .tx_ready_in(tx_ready_in), .rx_data(rx_data), .status(status)
    );

    // {len[21:20], par_on[19], par_odd[18], bad_par[17], stop[16], data[15:8], exp_status[7:0]}
    localparam logic [21:0] VEC [8] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h01},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF3, 8'h01},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h35, 8'h01},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0F, 8'h21},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2A, 8'h41},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81, 8'h01},
        {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h07, 8'h21},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3F, 8'h41}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_len(input logic [7:0] d, input int nb);
        logic [7:0] m = '0;
        for (int i = 0; i < nb; i++) m[i] = d[i];
        return m;
    endfunction

    task automatic send(input logic [7:0] d, input int nb, input logic pen,
                        input logic podd, input logic badpar, input logic stopv);
        logic [7:0] md = mask_len(d, nb);
        rxd = 1'b0; wait_clk(BIT);
        for (int i = 0; i < nb; i++) begin
            rxd = md[i]; wait_clk(BIT);
        end
        if (pen) begin
            rxd = ^md ^ podd ^ badpar; wait_clk(BIT);
        end
        if (stopv) begin
            rxd = 1'b1; wait_clk(BIT);
        end else begin
            rxd = 1'b0; wait_clk(40);
            rxd = 1'b1; wait_clk(BIT - 40);
        end
        rxd = 1'b1; wait_clk(BIT);
    endtask

    task automatic do_pop();
        pop = 1'b1; wait_clk(1); pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R1 reset status", status, 8'h00);
        chk("R11 reset data", rx_data, 8'h00);

        // Vector table walk: R2 R4 R5 R11
        for (int v = 0; v < 8; v++) begin
            logic [21:0] e = VEC[v];
            int nb = int'(e[21:20]) + 5;
            char_len = e[21:20]; par_on = e[19]; par_odd = e[18];
            send(e[15:8], nb, e[19], e[18], e[17], e[16]);
            chk($sformatf("R2/R4/R5 vec%0d status", v), status, e[7:0]);
            chk($sformatf("R2 vec%0d data", v), rx_data, mask_len(e[15:8], nb));
            do_pop();
            chk($sformatf("R11 vec%0d after pop", v), status, 8'h00);
        end
        char_len = 2'd3; par_on = 1'b0; par_odd = 1'b0;

        // R12 pass-through
        tx_empty_in = 1'b1; tx_ready_in = 1'b1; wait_clk(1);
        chk("R12 both tx flags", status, 8'h0C);
        tx_ready_in = 1'b0; wait_clk(1);
        chk("R12 tx empty only", status, 8'h08);
        tx_empty_in = 1'b0; wait_clk(1);

        // R3 false start
        rxd = 1'b0; wait_clk(8); rxd = 1'b1; wait_clk(2 * BIT);
        chk("R3 false start ignored", status, 8'h00);
        send(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 char after false start", rx_data, 8'h3C);
        do_pop();

        // R6 break, R7 inhibit with short high glitch
        rxd = 1'b0; wait_clk(12 * BIT);
        rxd = 1'b1; wait_clk(20);
        rxd = 1'b0; wait_clk(12 * BIT);
        rxd = 1'b1; wait_clk(BIT);
        chk("R6 break status", status, 8'hC1);
        chk("R6 break data", rx_data, 8'h00);
        do_pop();
        chk("R7 single entry across glitch", status, 8'h00);
        send(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 char after release", status, 8'h01);
        chk("R7 char data", rx_data, 8'h5A);
        do_pop();

        // R8 break starting mid-character
        rxd = 1'b0; wait_clk(BIT);
        rxd = 1'b1; wait_clk(3 * BIT);
        rxd = 1'b0; wait_clk(24 * BIT);
        rxd = 1'b1; wait_clk(2 * BIT);
        chk("R8 first entry framing", status, 8'h41);
        chk("R8 first entry data", rx_data, 8'h07);
        do_pop();
        chk("R8 second entry break", status, 8'hC1);
        do_pop();
        chk("R8 no third entry", status, 8'h00);

        // R9 full queue, R10 overrun
        send(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        send(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        send(8'h33, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 full", status, 8'h03);
        send(8'h44, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 overrun set", status, 8'h13);
        chk("R9 order 1", rx_data, 8'h11);
        do_pop();
        chk("R9 order 2", rx_data, 8'h22);
        do_pop();
        chk("R9 order 3", rx_data, 8'h33);
        do_pop();
        chk("R10 overrun sticky, dropped char", status, 8'h10);
        clr_err = 1'b1; wait_clk(1); clr_err = 1'b0;
        chk("R10 overrun cleared", status, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule